// File: doc/BRIEF.md
# Trap Return Privilege Stack Unit

This unit holds the status state of a small hart that runs in one of two privilege levels, machine (3) or user (0). It carries out the two return-from-trap operations. A return request names its target level through a two-bit flag field. The unit checks that the target is not above the current level. A legal return pops the interrupt-enable stack for that level, sets the new privilege, loads the next program counter from the exception-PC register of that level, and sends a one-cycle pulse that asks the interrupt controller to re-evaluate pending interrupts. An illegal return changes no state and raises an illegal-instruction trap with cause 2.

A trap-entry input pushes the stack in the other direction, so that entry and return can be paired in a round trip. A small CSR write port (address, data, write enable) loads the two exception-PC registers and the interrupt-enable register. No data flows through the unit as a stream. Every input is a plain control pin that is sampled on each rising clock edge, and the unit never applies back-pressure: a request is taken in the cycle it is presented. Every output is registered and shows the effect of a request one cycle later.

Top module: `trap_ret_unit`

## Requirements
- R1: After reset: priv = 3, status_o = 0x1800 (previous-privilege field status_o[12:11] = 3), ie_o = 0, next_pc = 0, and next_pc_vld, illegal, irq_recheck and trap_cause are all 0.
- R2: The target level of a return is 3 (machine) when either bit of ret_flags is 1. It is 0 (user) when both bits are 0.
- R3: A return whose target level is above priv leaves priv and status_o unchanged. One cycle later it pulses illegal for one cycle with trap_cause = 2 and does not pulse next_pc_vld or irq_recheck.
- R4: A legal machine return sets priv to the old status_o[12:11] and clears status_o[12:11] to 0. It copies status_o[7] (previous machine enable) into status_o[3] (machine enable), then sets status_o[7] to 1.
- R5: A legal user return sets priv to 0, copies status_o[4] (previous user enable) into status_o[0] (user enable), and then sets status_o[4] to 1.
- R6: A legal return drives next_pc, one cycle later, from the exception-PC register of its target level, with next_pc_vld high for that cycle. The register's CSR address is 0x041 with the level in bits 9:8: 0x041 for user and 0x341 for machine. next_pc holds its value between legal returns.
- R7: An exception-PC register stores csr_wdata with bit 0 forced to 0.
- R8: A CSR write to address 0x304 loads ie_o with csr_wdata. While priv = 0, bits 5:4 of ie_o (the supervisor and user timer enables) keep their old value.
- R9: irq_recheck pulses one cycle after each legal return, and at no other time.
- R10: trap_req copies priv into status_o[12:11] and status_o[3] into status_o[7], clears status_o[3], and sets priv to 3.
- R11: When trap_req and ret_req are high in the same cycle, the trap is taken and the return is dropped: it produces no illegal, next_pc_vld or irq_recheck pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ret_req | input | 1 | Return request, one cycle per instruction |
| ret_flags | input | 2 | Return-level flags; a nonzero value targets machine level |
| trap_req | input | 1 | Trap entry; pushes the enable and privilege stack |
| csr_we | input | 1 | CSR write enable |
| csr_addr | input | CSR_AW | CSR write address |
| csr_wdata | input | XLEN | CSR write data |
| priv | output | 2 | Current privilege (0 user, 3 machine) |
| status_o | output | XLEN | Status register |
| ie_o | output | XLEN | Interrupt-enable register |
| next_pc | output | XLEN | Program counter to resume at after a return |
| next_pc_vld | output | 1 | next_pc was loaded by a legal return in the previous cycle |
| illegal | output | 1 | Illegal-instruction trap pulse |
| trap_cause | output | 4 | Cause code, 2 while illegal is high |
| irq_recheck | output | 1 | Request to re-evaluate pending interrupts |

## Verification
On every cycle the checker verifies the pop sequences for machine and user returns, the push on trap entry, and the fact that an illegal return changes no state. It also checks that the re-evaluation pulse appears only together with a legal return, that next_pc never carries bit 0 set, and that the timer enables hold during writes made in user mode. Some behaviours can only be shown by the bench's scenarios. These include: which exception-PC register supplies next_pc, how the reset value of the previous-privilege field makes the first machine return stay in machine mode, and entry-and-return round trips that restore the enables. They also include the same-cycle collision of a trap and a return, and a CSR write that lands in the same cycle as a return that reads the register being written.

// File: rtl/trs_pkg.sv
package trs_pkg;
  localparam logic [1:0] LVL_USER    = 2'b00;
  localparam logic [1:0] LVL_MACHINE = 2'b11;

  // status register bit positions
  localparam int ST_UIE  = 0;
  localparam int ST_MIE  = 3;
  localparam int ST_UPIE = 4;
  localparam int ST_MPIE = 7;
  localparam int ST_PPL  = 11;  // two-bit previous-privilege field at 12:11
  localparam logic [31:0] ST_RESET = 32'h0000_1800;

  // CSR addresses
  localparam logic [11:0] ADDR_EPC_BASE = 12'h041;
  localparam logic [11:0] ADDR_IE       = 12'h304;
  localparam logic [31:0] IE_USER_LOCK  = 32'h0000_0030;

  localparam logic [3:0] CAUSE_ILLEGAL = 4'd2;
endpackage

// File: rtl/trs_status.sv
module trs_status
  import trs_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            do_trap,
  input  logic            do_mret,
  input  logic            do_uret,
  output logic [1:0]      priv,
  output logic [XLEN-1:0] status
);
  logic [1:0]      priv_q;
  logic [XLEN-1:0] st_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      priv_q <= LVL_MACHINE;
      st_q   <= XLEN'(ST_RESET);
    end else if (do_trap) begin
      st_q[ST_PPL+1:ST_PPL] <= priv_q;
      st_q[ST_MPIE]         <= st_q[ST_MIE];
      st_q[ST_MIE]          <= 1'b0;
      priv_q                <= LVL_MACHINE;
    end else if (do_mret) begin
      priv_q                <= st_q[ST_PPL+1:ST_PPL];
      st_q[ST_PPL+1:ST_PPL] <= LVL_USER;
      st_q[ST_MIE]          <= st_q[ST_MPIE];
      st_q[ST_MPIE]         <= 1'b1;
    end else if (do_uret) begin
      priv_q        <= LVL_USER;
      st_q[ST_UIE]  <= st_q[ST_UPIE];
      st_q[ST_UPIE] <= 1'b1;
    end
  end

  assign priv   = priv_q;
  assign status = st_q;
endmodule

// File: rtl/trs_epc_bank.sv
module trs_epc_bank
  import trs_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int CSR_AW = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_we,
  input  logic [CSR_AW-1:0] csr_addr,
  input  logic [XLEN-1:0]   csr_wdata,
  input  logic              rd_machine,
  output logic [XLEN-1:0]   rd_data
);
  localparam int NLVL = 2;
  logic [XLEN-1:0] epc_q [NLVL];

  for (genvar g = 0; g < NLVL; g++) begin : g_lvl
    localparam logic [1:0]  LVL  = (g == 0) ? LVL_USER : LVL_MACHINE;
    localparam logic [11:0] ADDR = ADDR_EPC_BASE | {2'b00, LVL, 8'h00};
    always_ff @(posedge clk) begin
      if (!rst_n)
        epc_q[g] <= '0;
      else if (csr_we && csr_addr == CSR_AW'(ADDR))
        epc_q[g] <= {csr_wdata[XLEN-1:1], 1'b0};
    end
  end

  assign rd_data = epc_q[rd_machine ? 1 : 0];
endmodule

// File: rtl/trs_ie_reg.sv
module trs_ie_reg
  import trs_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int CSR_AW = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_we,
  input  logic [CSR_AW-1:0] csr_addr,
  input  logic [XLEN-1:0]   csr_wdata,
  input  logic [1:0]        priv,
  output logic [XLEN-1:0]   ie
);
  logic [XLEN-1:0] ie_q;
  logic [XLEN-1:0] wmask;

  always_comb begin
    wmask = '1;
    if (priv == LVL_USER) wmask = ~XLEN'(IE_USER_LOCK);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      ie_q <= '0;
    else if (csr_we && csr_addr == CSR_AW'(ADDR_IE))
      ie_q <= (ie_q & ~wmask) | (csr_wdata & wmask);
  end

  assign ie = ie_q;
endmodule

// File: rtl/trap_ret_unit.sv
module trap_ret_unit
  import trs_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int CSR_AW = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ret_req,
  input  logic [1:0]        ret_flags,
  input  logic              trap_req,
  input  logic              csr_we,
  input  logic [CSR_AW-1:0] csr_addr,
  input  logic [XLEN-1:0]   csr_wdata,
  output logic [1:0]        priv,
  output logic [XLEN-1:0]   status_o,
  output logic [XLEN-1:0]   ie_o,
  output logic [XLEN-1:0]   next_pc,
  output logic              next_pc_vld,
  output logic              illegal,
  output logic [3:0]        trap_cause,
  output logic              irq_recheck
);
  logic            tgt_machine;
  logic [1:0]      tgt_lvl;
  logic            ret_take, ret_bad, ret_ok;
  logic [XLEN-1:0] epc_rd;
  logic            npc_vld_q, ill_q;
  logic [XLEN-1:0] npc_q;

  assign tgt_machine = |ret_flags;
  assign tgt_lvl     = tgt_machine ? LVL_MACHINE : LVL_USER;
  assign ret_take    = ret_req && !trap_req;
  assign ret_bad     = ret_take && (tgt_lvl > priv);
  assign ret_ok      = ret_take && !ret_bad;

  trs_status #(.XLEN(XLEN)) u_status (
    .clk(clk), .rst_n(rst_n), .do_trap(trap_req),
    .do_mret(ret_ok && tgt_machine), .do_uret(ret_ok && !tgt_machine),
    .priv(priv), .status(status_o)
  );

  trs_epc_bank #(.XLEN(XLEN), .CSR_AW(CSR_AW)) u_epc (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .rd_machine(tgt_machine), .rd_data(epc_rd)
  );

  trs_ie_reg #(.XLEN(XLEN), .CSR_AW(CSR_AW)) u_ie (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .priv(priv), .ie(ie_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      npc_q     <= '0;
      npc_vld_q <= 1'b0;
      ill_q     <= 1'b0;
    end else begin
      npc_vld_q <= ret_ok;
      ill_q     <= ret_bad;
      if (ret_ok) npc_q <= epc_rd;
    end
  end

  assign next_pc     = npc_q;
  assign next_pc_vld = npc_vld_q;
  assign irq_recheck = npc_vld_q;
  assign illegal     = ill_q;
  assign trap_cause  = ill_q ? CAUSE_ILLEGAL : 4'd0;
endmodule

// File: rtl/trs_checker.sv
module trs_checker #(
  parameter int XLEN   = 32,
  parameter int CSR_AW = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ret_req,
  input logic [1:0]        ret_flags,
  input logic              trap_req,
  input logic              csr_we,
  input logic [CSR_AW-1:0] csr_addr,
  input logic [1:0]        priv,
  input logic [XLEN-1:0]   status_o,
  input logic [XLEN-1:0]   ie_o,
  input logic [XLEN-1:0]   next_pc,
  input logic              next_pc_vld,
  input logic              illegal,
  input logic [3:0]        trap_cause,
  input logic              irq_recheck
);
  p_bad_ret_no_change_r3: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (priv == $past(priv)) && (status_o == $past(status_o))
                && trap_cause == 4'd2 && !next_pc_vld && !irq_recheck);

  p_mret_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && !trap_req && ret_flags != 2'b00 && priv == 2'b11) |=>
      (priv == $past(status_o[12:11])) && (status_o[12:11] == 2'b00)
      && (status_o[3] == $past(status_o[7])) && status_o[7]);

  p_uret_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && !trap_req && ret_flags == 2'b00) |=>
      (priv == 2'b00) && (status_o[0] == $past(status_o[4])) && status_o[4]);

  p_npc_even_r7: assert property (@(posedge clk) disable iff (!rst_n)
    next_pc_vld |-> next_pc[0] == 1'b0);

  p_ie_user_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && csr_addr == CSR_AW'(12'h304) && priv == 2'b00) |=>
      ie_o[5:4] == $past(ie_o[5:4]));

  p_recheck_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_recheck |-> $past(ret_req) && !$past(trap_req) && !illegal);

  p_trap_push_r10: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |=> (priv == 2'b11) && (status_o[12:11] == $past(priv))
                 && (status_o[7] == $past(status_o[3])) && !status_o[3]);

  p_trap_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && ret_req) |=> !illegal && !next_pc_vld);
endmodule

bind trap_ret_unit trs_checker #(.XLEN(XLEN), .CSR_AW(CSR_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ret_req(ret_req), .ret_flags(ret_flags),
  .trap_req(trap_req), .csr_we(csr_we), .csr_addr(csr_addr), .priv(priv),
  .status_o(status_o), .ie_o(ie_o), .next_pc(next_pc),
  .next_pc_vld(next_pc_vld), .illegal(illegal), .trap_cause(trap_cause),
  .irq_recheck(irq_recheck)
);

// File: tb/sim_trap_ret_unit.sv
`timescale 1ns/1ps
module sim_trap_ret_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ret_req = 1'b0;
  logic [1:0]  ret_flags = 2'b00;
  logic        trap_req = 1'b0;
  logic        csr_we = 1'b0;
  logic [11:0] csr_addr = 12'h0;
  logic [31:0] csr_wdata = 32'h0;
  logic [1:0]  priv;
  logic [31:0] status_o, ie_o, next_pc;
  logic        next_pc_vld, illegal, irq_recheck;
  logic [3:0]  trap_cause;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // reference model state
  logic [1:0]  m_priv;
  logic [31:0] m_st, m_ie, m_epc_u, m_epc_m, m_npc;
  logic        m_nv, m_ill;

  always #4 clk = ~clk;  // 125 MHz

  trap_ret_unit u0 (
    .clk(clk), .rst_n(rst_n), .ret_req(ret_req), .ret_flags(ret_flags),
    .trap_req(trap_req), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .priv(priv), .status_o(status_o), .ie_o(ie_o),
    .next_pc(next_pc), .next_pc_vld(next_pc_vld), .illegal(illegal),
    .trap_cause(trap_cause), .irq_recheck(irq_recheck)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R1 R2 R4 R5 R10 priv", {30'd0, priv}, {30'd0, m_priv});
    chk("R1 R4 R5 R10 R11 status", status_o, m_st);
    chk("R8 ie", ie_o, m_ie);
    chk("R6 R7 next_pc", next_pc, m_npc);
    chk("R6 next_pc_vld", {31'd0, next_pc_vld}, {31'd0, m_nv});
    chk("R9 irq_recheck", {31'd0, irq_recheck}, {31'd0, m_nv});
    chk("R3 R11 illegal", {31'd0, illegal}, {31'd0, m_ill});
    chk("R3 trap_cause", {28'd0, trap_cause}, m_ill ? 32'd2 : 32'd0);
  endtask

  task automatic model_reset();
    m_priv = 2'd3; m_st = 32'h1800; m_ie = 0; m_epc_u = 0; m_epc_m = 0;
    m_npc = 0; m_nv = 0; m_ill = 0;
  endtask

  task automatic model_step();
    logic [1:0]  old_priv, tl;
    logic [31:0] msk;
    old_priv = m_priv;
    tl = (ret_flags != 2'b00) ? 2'd3 : 2'd0;
    m_nv = 0; m_ill = 0;
    if (trap_req) begin
      m_st[12:11] = m_priv; m_st[7] = m_st[3]; m_st[3] = 1'b0; m_priv = 2'd3;
    end else if (ret_req) begin
      if (tl > m_priv) m_ill = 1;
      else begin
        m_nv = 1;
        m_npc = (tl == 2'd3) ? m_epc_m : m_epc_u;
        if (tl == 2'd3) begin
          m_priv = m_st[12:11]; m_st[12:11] = 2'd0; m_st[3] = m_st[7]; m_st[7] = 1'b1;
        end else begin
          m_priv = 2'd0; m_st[0] = m_st[4]; m_st[4] = 1'b1;
        end
      end
    end
    if (csr_we) begin
      if (csr_addr == 12'h041) m_epc_u = csr_wdata & ~32'h1;
      if (csr_addr == 12'h341) m_epc_m = csr_wdata & ~32'h1;
      if (csr_addr == 12'h304) begin
        msk = (old_priv == 2'd0) ? ~32'h30 : 32'hFFFF_FFFF;
        m_ie = (m_ie & ~msk) | (csr_wdata & msk);
      end
    end
  endtask

  task automatic cyc(input logic rr, input logic [1:0] rf, input logic tr,
                     input logic we, input logic [11:0] a, input logic [31:0] d);
    ret_req = rr; ret_flags = rf; trap_req = tr;
    csr_we = we; csr_addr = a; csr_wdata = d;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle(); cyc(0, 2'b00, 0, 0, 12'h0, 32'h0); endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    compare_all();                      // R1 reset state
    rst_n = 1'b1;
    idle();
    // R7: epc writes with bit 0 set
    cyc(0, 2'b00, 0, 1, 12'h341, 32'h0000_2001);
    cyc(0, 2'b00, 0, 1, 12'h041, 32'h0000_3003);
    // R4 + R1: first MRET from reset keeps machine mode (MPP=3)
    cyc(1, 2'b10, 0, 0, 12'h0, 32'h0);
    idle();
    // MRET with MPP now 0 -> user (R2 flag 01)
    cyc(1, 2'b01, 0, 0, 12'h0, 32'h0);
    idle();
    // R3: MRET from user is illegal
    cyc(1, 2'b11, 0, 0, 12'h0, 32'h0);
    // R8: user-mode ie write keeps bits 5:4
    cyc(0, 2'b00, 0, 1, 12'h304, 32'hFFFF_FFFF);
    // R5: URET from user
    cyc(1, 2'b00, 0, 0, 12'h0, 32'h0);
    // R10 trap then R4 round trip back to user
    cyc(0, 2'b00, 1, 0, 12'h0, 32'h0);
    cyc(0, 2'b00, 0, 1, 12'h304, 32'hFFFF_FFFF);
    cyc(1, 2'b11, 0, 0, 12'h0, 32'h0);
    // R11 collision
    cyc(1, 2'b01, 1, 0, 12'h0, 32'h0);
    // R6: write epc in same cycle as return reading it
    cyc(1, 2'b10, 0, 1, 12'h341, 32'h0000_5555);
    cyc(1, 2'b10, 0, 0, 12'h0, 32'h0);
    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic [11:0] a;
      case ($urandom_range(0, 3))
        0: a = 12'h041; 1: a = 12'h341; 2: a = 12'h304; default: a = 12'h123;
      endcase
      cyc($urandom_range(0, 9) < 4, 2'($urandom_range(0, 3)),
          $urandom_range(0, 9) < 1, $urandom_range(0, 9) < 3, a, $urandom);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule